// File: doc/BRIEF.md
# Burst Target Responder for a Multiplexed Address/Data Bus

This block is the slave side of a 32-bit bus on which address and data share the same wires. Each transaction opens with an address phase. The block compares that address with a window that starts at a base supplied on a port. The window size is a parameter equal to the number of 32-bit registers in a small internal bank. When the address falls inside the window and the command is a memory read or a memory write, the block claims the cycle and serves a burst of data phases from its bank.

On writes, each byte lane is written only when its active-low byte enable is low. The block can hold its ready signal off for zero to three cycles before each data phase. When a burst would run past the last register of the window, the block asks the initiator to stop.

Every bus signal is split into an input, an output and an output enable, so the pad ring can add tristates outside the block. A system that uses it ties `base_addr` and `wait_cfg` from its own configuration logic. It connects the split bus signals to its pad drivers.

Top module: `tgt_bus_target`

## Requirements
- R1: While `rst_n` is low, all output enables (`ad_oe`, `ctl_oe`, `perr_oe`) are 0, and `devsel_n_out`, `trdy_n_out`, `stop_n_out` and `perr_n_out` are 1.
- R2: An address phase is the first rising edge at which `frame_n` is low after being high. At that edge the block captures `ad_in` as the address and `cbe_n` as the command. It claims only the commands 4'b0110 (memory read) and 4'b0111 (memory write), and only when `ad_in[31:W]` equals `base_addr[31:W]`, with W = log2(REG_WORDS)+2. For every other command or address, `devsel_n_out` and `ctl_oe` stay inactive for the whole transaction.
- R3: For a claimed address, `devsel_n_out` is low from the cycle after the address-phase edge.
- R4: The first word index is `ad_in[W-1:2]` of the address. Each completed data phase that is not the last adds 1 to the index. During a read, `ad_out` holds the register at the current index, and `ad_oe` is 1.
- R5: After the claim edge, and after each completed data phase, `trdy_n_out` stays high for exactly `wait_cfg` cycles and then goes low.
- R6: A word moves only at a rising edge where `irdy_n` and `trdy_n_out` are both low. On a write, byte lane b (`ad_in[8b+7:8b]`) of the register changes only if `cbe_n[b]` is 0.
- R7: `stop_n_out` goes low together with `trdy_n_out` when the current index is the last register of the window, REG_WORDS-1. No further word moves in that transaction.
- R8: A transaction ends at a transfer where `frame_n` is high or `stop_n_out` is low. In the next cycle, `devsel_n_out`, `trdy_n_out` and `stop_n_out` are all high together, and `ctl_oe` is 0. The block returns to idle once `frame_n` and `irdy_n` are both high.
- R9: On each write transfer, the XOR of `ad_in`, `cbe_n` and `par_in` must be 0 (even parity). If it is not, `perr_n_out` is low for one cycle after the transfer edge, with `perr_oe` high. A write with bad parity still updates the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction framing from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address/data received from the bus |
| cbe_n | input | 4 | Command in the address phase, byte enables in data phases, active low |
| par_in | input | 1 | Even parity bit that accompanies `ad_in` and `cbe_n` |
| base_addr | input | 32 | Start of the register window; bits below W are ignored |
| wait_cfg | input | 2 | Wait cycles inserted before each data transfer |
| ad_out | output | 32 | Read data driven toward the bus |
| ad_oe | output | 1 | Enable for `ad_out` |
| devsel_n_out | output | 1 | Claim signal, active low |
| trdy_n_out | output | 1 | Target ready, active low |
| stop_n_out | output | 1 | Termination request, active low |
| ctl_oe | output | 1 | Enable for the claim, ready and stop outputs |
| perr_n_out | output | 1 | Data parity error flag, active low |
| perr_oe | output | 1 | Enable for `perr_n_out` |

## Verification
A corrupted word index shows up as wrong read data on the next read transfer. On a write, it shows up at the next read-back of the affected register. A wrong stop decision shows up at the same transfer, either as a burst that stops too early or one that passes the window end. A wrong wait count changes the number of cycles that `trdy_n_out` stays high in the very next data phase. A stuck state machine appears within one cycle as a claim signal that fails to drop together with ready and stop. It can also appear as a later address phase that the block does not claim. A wrong parity fold appears one cycle after the write transfer as a missing or spurious `perr_n_out` pulse.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_BUSY = 2'd2
    } tgt_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/tgt_addr_decode.sv
module tgt_addr_decode #(
    parameter int REG_WORDS = 8,
    localparam int IDX_W    = $clog2(REG_WORDS),
    localparam int WIN_LSB  = IDX_W + 2
) (
    input  logic [31:0]      addr,
    input  logic [3:0]       cmd,
    input  logic [31:0]      base,
    output logic             hit,
    output logic             is_wr,
    output logic [IDX_W-1:0] idx
);
    import tgt_pkg::*;

    logic in_window;
    logic mem_cmd;
    logic unused_bits;

    assign in_window   = (addr[31:WIN_LSB] == base[31:WIN_LSB]);
    assign mem_cmd     = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    assign hit         = in_window && mem_cmd;
    assign is_wr       = (cmd == CMD_MEM_WR);
    assign idx         = addr[WIN_LSB-1:2];
    assign unused_bits = ^{addr[1:0], base[WIN_LSB-1:0]};
endmodule

// File: rtl/tgt_regbank.sv
module tgt_regbank #(
    parameter int REG_WORDS = 8,
    localparam int IDX_W    = $clog2(REG_WORDS),
    localparam int LANES    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [LANES-1:0] wr_be,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);
    logic [31:0] words [REG_WORDS];

    for (genvar w = 0; w < REG_WORDS; w++) begin : g_word
        logic [31:0] word_q;
        logic        sel;
        assign sel = wr_en && (wr_idx == IDX_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                for (int b = 0; b < LANES; b++) begin
                    if (sel && wr_be[b]) begin
                        word_q[8*b +: 8] <= wr_data[8*b +: 8];
                    end
                end
            end
        end
        assign words[w] = word_q;
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/tgt_parity_chk.sv
module tgt_parity_chk (
    input  logic [31:0] ad,
    input  logic [3:0]  cbe_n,
    input  logic        par,
    output logic        par_ok
);
    assign par_ok = ~(^{ad, cbe_n, par});
endmodule

// File: rtl/tgt_bus_target.sv
module tgt_bus_target #(
    parameter int REG_WORDS = 8,
    localparam int IDX_W    = $clog2(REG_WORDS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic [31:0] ad_in,
    input  logic [3:0]  cbe_n,
    input  logic        par_in,
    input  logic [31:0] base_addr,
    input  logic [1:0]  wait_cfg,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        devsel_n_out,
    output logic        trdy_n_out,
    output logic        stop_n_out,
    output logic        ctl_oe,
    output logic        perr_n_out,
    output logic        perr_oe
);
    import tgt_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_WORDS - 1);

    typedef struct packed {
        tgt_state_e       st;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [1:0]       wcnt;
        logic             devsel;
        logic             trdy;
        logic             stop;
        logic             perr;
        logic             perr_en;
        logic             frame_prev;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic             dec_hit;
    logic             dec_wr;
    logic [IDX_W-1:0] dec_idx;
    logic             par_ok;
    logic             xfer;
    logic             no_wait;
    logic [1:0]       wait_load;
    logic [IDX_W-1:0] idx_inc;
    logic [31:0]      rd_data;

    tgt_addr_decode #(.REG_WORDS(REG_WORDS)) u_dec (
        .addr  (ad_in),
        .cmd   (cbe_n),
        .base  (base_addr),
        .hit   (dec_hit),
        .is_wr (dec_wr),
        .idx   (dec_idx)
    );

    tgt_parity_chk u_par (
        .ad     (ad_in),
        .cbe_n  (cbe_n),
        .par    (par_in),
        .par_ok (par_ok)
    );

    tgt_regbank #(.REG_WORDS(REG_WORDS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (xfer && ctx_q.wr),
        .wr_idx  (ctx_q.idx),
        .wr_data (ad_in),
        .wr_be   (~cbe_n),
        .rd_idx  (ctx_q.idx),
        .rd_data (rd_data)
    );

    assign xfer      = (ctx_q.st == ST_DATA) && ctx_q.trdy && !irdy_n;
    assign no_wait   = (wait_cfg == 2'd0);
    assign wait_load = no_wait ? 2'd0 : 2'(wait_cfg - 2'd1);
    assign idx_inc   = IDX_W'(ctx_q.idx + 1'b1);

    always_comb begin
        ctx_d            = ctx_q;
        ctx_d.frame_prev = frame_n;
        ctx_d.perr       = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (ctx_q.frame_prev && !frame_n) begin
                    if (dec_hit) begin
                        ctx_d.st     = ST_DATA;
                        ctx_d.wr     = dec_wr;
                        ctx_d.idx    = dec_idx;
                        ctx_d.devsel = 1'b1;
                        ctx_d.trdy   = no_wait;
                        ctx_d.stop   = no_wait && (dec_idx == LAST_IDX);
                        ctx_d.wcnt   = wait_load;
                    end else begin
                        ctx_d.st = ST_BUSY;
                    end
                end
            end
            ST_DATA: begin
                if (xfer) begin
                    ctx_d.perr = ctx_q.wr && !par_ok;
                    if (frame_n || ctx_q.stop) begin
                        ctx_d.st     = frame_n ? ST_IDLE : ST_BUSY;
                        ctx_d.devsel = 1'b0;
                        ctx_d.trdy   = 1'b0;
                        ctx_d.stop   = 1'b0;
                    end else begin
                        ctx_d.idx  = idx_inc;
                        ctx_d.trdy = no_wait;
                        ctx_d.stop = no_wait && (idx_inc == LAST_IDX);
                        ctx_d.wcnt = wait_load;
                    end
                end else if (!ctx_q.trdy) begin
                    if (ctx_q.wcnt == 2'd0) begin
                        ctx_d.trdy = 1'b1;
                        ctx_d.stop = (ctx_q.idx == LAST_IDX);
                    end else begin
                        ctx_d.wcnt = ctx_q.wcnt - 2'd1;
                    end
                end
            end
            ST_BUSY: begin
                if (frame_n && irdy_n) begin
                    ctx_d.st = ST_IDLE;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
        ctx_d.perr_en = ((ctx_d.st == ST_DATA) && ctx_d.wr) || ctx_d.perr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q            <= '0;
            ctx_q.st         <= ST_IDLE;
            ctx_q.frame_prev <= 1'b1;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign ad_out       = rd_data;
    assign ad_oe        = ctx_q.devsel && !ctx_q.wr;
    assign devsel_n_out = ~ctx_q.devsel;
    assign trdy_n_out   = ~ctx_q.trdy;
    assign stop_n_out   = ~ctx_q.stop;
    assign ctl_oe       = ctx_q.devsel;
    assign perr_n_out   = ~ctx_q.perr;
    assign perr_oe      = ctx_q.perr_en;

    // R5
    trdy_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n_out |-> (!devsel_n_out && ctl_oe));

    // R7
    stop_with_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n_out |-> (!trdy_n_out && !devsel_n_out));

    // R8
    release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_n_out) |-> (trdy_n_out && stop_n_out && !ctl_oe));

    // R4
    index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !frame_n && !ctx_q.stop) |=> (ctx_q.idx == IDX_W'($past(ctx_q.idx) + 1'b1)));

    // R4
    read_drive_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> ctl_oe);

    // R9
    perr_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n_out |-> perr_oe);
endmodule

// File: tb/tgt_bus_target_tb.sv
module tgt_bus_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int REG_WORDS  = 8;
    localparam int WD_CYCLES  = 20000;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        par_in = 1'b0;
    logic [1:0]  wait_cfg = 2'd0;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n_out, trdy_n_out, stop_n_out, ctl_oe, perr_n_out, perr_oe;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [31:0] model [REG_WORDS];
    logic [31:0] exp_q [$];
    bit perr_pend = 1'b0;
    bit perr_exp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tgt_bus_target #(.REG_WORDS(REG_WORDS)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad_in(ad_in), .cbe_n(cbe_n), .par_in(par_in), .base_addr(BASE),
        .wait_cfg(wait_cfg), .ad_out(ad_out), .ad_oe(ad_oe),
        .devsel_n_out(devsel_n_out), .trdy_n_out(trdy_n_out),
        .stop_n_out(stop_n_out), .ctl_oe(ctl_oe),
        .perr_n_out(perr_n_out), .perr_oe(perr_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic [31:0] wdata(input int idx, input int seed);
        return 32'hC0DE_0000 ^ (32'(seed) << 8) ^ (32'(idx) * 32'h0101_0101);
    endfunction

    // Monitor: pops expected read words at real transfers; tracks parity reports (R4, R6, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (perr_pend) begin
                chk(perr_n_out == !perr_exp && (perr_exp ? perr_oe : 1'b1), "R9",
                    "perr after write", 32'(perr_n_out), 32'(!perr_exp));
                perr_pend = 1'b0;
            end else if (!perr_n_out) begin
                chk(1'b0, "R9", "spurious perr", 32'(perr_n_out), 32'd1);
            end
            if (ad_oe && !trdy_n_out && !irdy_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "read transfer with no expectation", ad_out, 32'hx);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(ad_out == e, "R4", "read data", ad_out, e);
                end
            end
            if (ctl_oe && !ad_oe && !trdy_n_out && !irdy_n) begin
                perr_pend = 1'b1;
                perr_exp  = ^{ad_in, cbe_n, par_in};
            end
        end
    end

    task automatic burst(input logic [31:0] addr, input bit wr, input int n,
                         input logic [3:0] be, input int bad_i, input int stall_i,
                         input int seed, output int done);
        int idx;
        bit stopped;
        idx = int'(addr[4:2]);
        stopped = 1'b0;
        done = 0;
        @(posedge clk); #1;
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr;
        cbe_n = wr ? 4'b0111 : 4'b0110; par_in = ^{ad_in, cbe_n};
        for (int i = 0; i < n && !stopped; i++) begin
            int cnt;
            bit first;
            @(posedge clk); #1;
            frame_n = (i == n - 1);
            irdy_n  = (i == stall_i);
            ad_in   = wr ? wdata(idx, seed) : 32'h0;
            cbe_n   = ~be;
            par_in  = (^{ad_in, cbe_n}) ^ (i == bad_i);
            if (!wr) exp_q.push_back(model[idx]);
            cnt = 0;
            first = (i == 0);
            forever begin
                @(negedge clk);
                if (first) begin
                    chk(!devsel_n_out, "R3", "claim after address phase", 32'(devsel_n_out), 32'd0);
                    first = 1'b0;
                end
                if (trdy_n_out) cnt++;
                if (!trdy_n_out && !irdy_n) break;
                if (cnt > 8) break;
                @(posedge clk); #1;
                irdy_n = 1'b0;
            end
            chk(cnt == int'(wait_cfg), "R5", "wait cycles before ready", 32'(cnt), 32'(wait_cfg));
            chk(stop_n_out == (idx != REG_WORDS - 1), "R7", "stop at window end",
                32'(stop_n_out), 32'(idx != REG_WORDS - 1));
            stopped = !stop_n_out;
            if (wr) begin
                for (int b = 0; b < 4; b++)
                    if (be[b]) model[idx][8*b +: 8] = ad_in[8*b +: 8];
            end
            done++;
            idx++;
        end
        @(posedge clk); #1;
        frame_n = 1'b1; irdy_n = 1'b1;
        @(negedge clk);
        chk(devsel_n_out && trdy_n_out && stop_n_out && !ctl_oe && !ad_oe, "R8",
            "outputs released together",
            {28'h0, devsel_n_out, trdy_n_out, stop_n_out, ctl_oe}, 32'he);
    endtask

    task automatic probe_miss(input logic [31:0] addr, input logic [3:0] cmd);
        @(posedge clk); #1;
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd; par_in = ^{addr, cmd};
        @(posedge clk); #1;
        frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0; ad_in = 32'hFFFF_FFFF;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(devsel_n_out && !ctl_oe && trdy_n_out, "R2", "no claim",
                32'(devsel_n_out), 32'd1);
        end
        @(posedge clk); #1;
        irdy_n = 1'b1;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            report();
        end
    end

    initial begin
        int done;
        for (int w = 0; w < REG_WORDS; w++) model[w] = '0;
        #(CLK_PERIOD * 2 + 1);
        // R1 reset state
        chk(!ad_oe && !ctl_oe && !perr_oe && devsel_n_out && trdy_n_out && stop_n_out && perr_n_out,
            "R1", "reset outputs", {25'h0, ad_oe, ctl_oe, perr_oe, devsel_n_out, trdy_n_out,
            stop_n_out, perr_n_out}, 32'hF);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R4 R6: full write burst then read back, no waits
        burst(BASE + 32'h0, 1'b1, 4, 4'hF, -1, -1, 1, done);
        chk(done == 4, "R4", "write burst length", 32'(done), 32'd4);
        burst(BASE + 32'h0, 1'b0, 4, 4'hF, -1, -1, 0, done);
        chk(done == 4, "R4", "read burst length", 32'(done), 32'd4);

        // R5 R6: waits, partial byte enables, initiator stall
        wait_cfg = 2'd2;
        burst(BASE + 32'h10, 1'b1, 2, 4'b0101, -1, 1, 2, done);
        wait_cfg = 2'd3;
        burst(BASE + 32'h10, 1'b0, 2, 4'hF, -1, 0, 0, done);
        burst(BASE + 32'h4, 1'b1, 1, 4'b1000, -1, -1, 3, done);
        wait_cfg = 2'd1;
        burst(BASE + 32'h0, 1'b0, 2, 4'hF, -1, 1, 0, done);

        // R7: bursts that would run past the window end
        wait_cfg = 2'd0;
        burst(BASE + 32'h18, 1'b1, 4, 4'hF, -1, -1, 4, done);
        chk(done == 2, "R7", "write stopped at end", 32'(done), 32'd2);
        wait_cfg = 2'd1;
        burst(BASE + 32'h14, 1'b0, 5, 4'hF, -1, -1, 0, done);
        chk(done == 3, "R7", "read stopped at end", 32'(done), 32'd3);

        // R2: outside window, non-memory command inside window
        probe_miss(32'h0000_2004, 4'b0110);
        probe_miss(BASE + 32'h8, 4'b0010);
        wait_cfg = 2'd0;
        burst(BASE + 32'h8, 1'b0, 1, 4'hF, -1, -1, 0, done);

        // R9: bad parity write still updates, and is flagged
        burst(BASE + 32'h4, 1'b1, 2, 4'hF, 1, -1, 5, done);
        burst(BASE + 32'h4, 1'b0, 2, 4'hF, -1, -1, 0, done);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "all reads consumed", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        report();
    end
endmodule